// File: doc/BRIEF.md
# Memory Bit-Field Operation Unit

This block carries out one bit-field operation at a time on a byte-wide, big-endian memory. A field is named by a base byte address, a signed bit offset and a 5-bit width code. From these the unit works out the first byte the field touches, the bit position inside that byte and how many bytes the field covers (one to five). It then reads those bytes one after another into a 40-bit window and applies the operation. The operations are signed extract, unsigned extract, insert, invert, clear, fill and find-first-one. For the four operations that modify memory, it writes the bytes back.

Every operation returns a 32-bit result and a flag word. The flag word holds the field aligned to the top of 32 bits, and the negative and zero flags are taken from it. A start pulse launches the operation. A one-cycle done pulse reports the result. The memory port issues one byte request per cycle and expects read data one cycle after a read request.

Top module: `bitfield_mem_unit`

## Requirements
- R1: Width code 0 selects a 32-bit field. Any other code n in 1..31 selects n bits, so the width is ((code - 1) mod 32) + 1.
- R2: The bit offset is signed two's complement. The first byte read is base + floor(offset / 8), and the bit position inside that byte is offset mod 8, always in 0..7. Bytes are read at ascending addresses, one per cycle.
- R3: The number of bytes read is floor((bitpos + width - 1) / 8) + 1, which ranges from 1 to 5. Each of those bytes is read exactly once and no other byte is accessed.
- R4: Field bit 0 is the most significant bit (bit 7) of the first byte. Later field bits follow in descending bit order and then continue into the next higher address.
- R5: Op code 0 returns the field sign-extended to 32 bits. Op code 1 returns it zero-extended. Op code 7 behaves as op code 1.
- R6: Op code 2 replaces the field with the low width bits of the insert value. The result value and the flag word are both that value left-justified in 32 bits.
- R7: Op codes 3, 4 and 5 invert, zero and fill the field respectively. Memory bits outside the field are not changed. The result value is the old field left-justified in 32 bits.
- R8: Op code 6 returns the offset plus the number of leading zeros of the field. If the field is all zeros, it returns the offset plus the width, as a 32-bit two's complement value.
- R9: The flag word is the inserted value for op code 2 and the old field left-justified for all other op codes. The negative flag equals bit 31 of the flag word. The zero flag is set exactly when the flag word is zero.
- R10: Op codes 2 to 5 write back exactly the bytes that were read, at ascending addresses, one per cycle, and only after the last read. Op codes 0, 1, 6 and 7 do not write.
- R11: With S = bytes read - 1, done pulses for one cycle. It pulses S+4 cycles after the start edge for non-writing ops and 2S+5 cycles after it for writing ops. Busy is high from the cycle after start until done. A start pulse while busy is ignored. After reset, busy, done, the memory request and the results are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch an operation (sampled when idle) |
| op | input | 3 | Operation code (see R5-R8) |
| base | input | ADDR_W | Base byte address |
| ofs | input | OFS_W | Signed bit offset |
| wcode | input | 5 | Width code, 0 means 32 |
| ins_val | input | 32 | Value for insert |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| res_value | output | 32 | Operation result |
| res_field | output | 32 | Flag word, field left-justified |
| res_n | output | 1 | Negative flag |
| res_z | output | 1 | Zero flag |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Write enable of the access |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |

## Verification
Cycles are counted from the start edge. The read for byte k is due in cycle k+1. Non-writing ops raise done in cycle S+4. For writing ops, write k is due in cycle S+4+k and done comes in cycle 2S+5. The bench model computes these figures from the offset and the width alone. On every falling edge it compares the memory port, busy and done against the value predicted for that exact cycle. It checks the result ports and the memory contents in the done cycle, and it uses a start pulse in the middle of an operation to confirm that busy holds off a new command.

// File: rtl/bfu_pkg.sv
package bfu_pkg;

  localparam int FIELD_W   = 32;
  localparam int WIN_BYTES = 5;
  localparam int WIN_W     = 8 * WIN_BYTES;
  localparam int WCODE_W   = $clog2(FIELD_W);
  localparam int WID_W     = WCODE_W + 1;
  localparam int IDX_W     = $clog2(WIN_BYTES);

  typedef enum logic [2:0] {
    OP_SEXT = 3'd0,
    OP_UEXT = 3'd1,
    OP_INS  = 3'd2,
    OP_FLIP = 3'd3,
    OP_ZERO = 3'd4,
    OP_FILL = 3'd5,
    OP_FIND = 3'd6,
    OP_ALT  = 3'd7
  } bf_op_e;

  function automatic logic op_writes(input bf_op_e o);
    return (o == OP_INS) || (o == OP_FLIP) || (o == OP_ZERO) || (o == OP_FILL);
  endfunction

endpackage

// File: rtl/bfu_locate.sv
module bfu_locate
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 32
) (
  input  logic [ADDR_W-1:0]       base,
  input  logic signed [OFS_W-1:0] ofs,
  input  logic [WCODE_W-1:0]      wcode,
  output logic [ADDR_W-1:0]       first_addr,
  output logic [2:0]              bitpos,
  output logic [WID_W-1:0]        width,
  output logic [IDX_W-1:0]        span
);

  // floor division by 8 is an arithmetic right shift of the signed offset
  assign first_addr = ADDR_W'(base + ADDR_W'(ofs >>> 3));
  assign bitpos     = ofs[2:0];
  assign width      = (wcode == '0) ? WID_W'(FIELD_W) : {1'b0, wcode};
  assign span       = IDX_W'(({{(WID_W-3){1'b0}}, bitpos} + width - WID_W'(1)) >> 3);

endmodule

// File: rtl/bfu_window.sv
module bfu_window
  import bfu_pkg::*;
#(
  parameter int NBYTES = WIN_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  ld_en,
  input  logic [8*NBYTES-1:0]   ld_win,
  input  logic                  cap_en,
  input  logic [IDX_W-1:0]      cap_idx,
  input  logic [7:0]            cap_byte,
  input  logic [IDX_W-1:0]      sel_idx,
  output logic [7:0]            sel_byte,
  output logic [8*NBYTES-1:0]   win
);

  // lane i holds the byte at first_addr + i, lane 0 in the top bits
  for (genvar i = 0; i < NBYTES; i++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        win[8*(NBYTES-i)-1 -: 8] <= 8'h00;
      end else if (ld_en) begin
        win[8*(NBYTES-i)-1 -: 8] <= ld_win[8*(NBYTES-i)-1 -: 8];
      end else if (cap_en && (cap_idx == IDX_W'(i))) begin
        win[8*(NBYTES-i)-1 -: 8] <= cap_byte;
      end
    end
  end

  always_comb begin
    sel_byte = 8'h00;
    for (int i = 0; i < NBYTES; i++) begin
      if (sel_idx == IDX_W'(i)) sel_byte = win[8*(NBYTES-i)-1 -: 8];
    end
  end

endmodule

// File: rtl/bfu_fieldop.sv
module bfu_fieldop
  import bfu_pkg::*;
#(
  parameter int OFS_W = 32
) (
  input  bf_op_e                  op,
  input  logic [WIN_W-1:0]        win,
  input  logic [2:0]              bitpos,
  input  logic [WID_W-1:0]        width,
  input  logic signed [OFS_W-1:0] ofs,
  input  logic [FIELD_W-1:0]      ins_val,
  output logic [WIN_W-1:0]        new_win,
  output logic [FIELD_W-1:0]      value,
  output logic [FIELD_W-1:0]      flag_word,
  output logic                    flag_n,
  output logic                    flag_z
);

  localparam int PAD = WIN_W - FIELD_W;

  logic [WID_W-1:0]   rsh;
  logic [FIELD_W-1:0] keep_mask;
  logic [FIELD_W-1:0] old_lj;
  logic [FIELD_W-1:0] ins_lj;
  logic [WIN_W-1:0]   mask_win;
  logic [WIN_W-1:0]   ins_win;
  logic [WID_W-1:0]   lead;
  logic [WID_W-1:0]   find_cnt;

  function automatic logic [WID_W-1:0] count_lead(input logic [FIELD_W-1:0] v);
    logic [WID_W-1:0] n;
    logic             hit;
    n   = '0;
    hit = 1'b0;
    for (int i = FIELD_W - 1; i >= 0; i--) begin
      if (v[i]) hit = 1'b1;
      else if (!hit) n = n + WID_W'(1);
    end
    return n;
  endfunction

  assign rsh       = WID_W'(FIELD_W) - width;
  assign keep_mask = {FIELD_W{1'b1}} << rsh;
  assign old_lj    = FIELD_W'((win << bitpos) >> PAD) & keep_mask;
  assign ins_lj    = ins_val << rsh;
  assign mask_win  = {keep_mask, {PAD{1'b0}}} >> bitpos;
  assign ins_win   = {ins_lj, {PAD{1'b0}}} >> bitpos;
  assign lead      = count_lead(old_lj);
  assign find_cnt  = (old_lj == '0) ? width : lead;

  always_comb begin
    new_win   = win;
    flag_word = old_lj;
    value     = old_lj >> rsh;
    unique case (op)
      OP_SEXT: value = FIELD_W'($signed(old_lj) >>> rsh);
      OP_UEXT, OP_ALT: value = old_lj >> rsh;
      OP_INS: begin
        new_win   = (win & ~mask_win) | ins_win;
        value     = ins_lj;
        flag_word = ins_lj;
      end
      OP_FLIP: begin
        new_win = win ^ mask_win;
        value   = old_lj;
      end
      OP_ZERO: begin
        new_win = win & ~mask_win;
        value   = old_lj;
      end
      OP_FILL: begin
        new_win = win | mask_win;
        value   = old_lj;
      end
      OP_FIND: value = FIELD_W'(ofs) + FIELD_W'(find_cnt);
      default: value = old_lj >> rsh;
    endcase
  end

  assign flag_n = flag_word[FIELD_W-1];
  assign flag_z = (flag_word == '0);

endmodule

// File: rtl/bitfield_mem_unit.sv
module bitfield_mem_unit
  import bfu_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 32
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [2:0]              op,
  input  logic [ADDR_W-1:0]       base,
  input  logic signed [OFS_W-1:0] ofs,
  input  logic [4:0]              wcode,
  input  logic [31:0]             ins_val,
  output logic                    busy,
  output logic                    done,
  output logic [31:0]             res_value,
  output logic [31:0]             res_field,
  output logic                    res_n,
  output logic                    res_z,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata
);

  typedef enum logic [2:0] {
    S_IDLE, S_READ, S_DRAIN, S_EXEC, S_WRITE
  } state_e;

  state_e                  st;
  bf_op_e                  op_q;
  logic [ADDR_W-1:0]       addr_q;
  logic [2:0]              bitpos_q;
  logic [WID_W-1:0]        width_q;
  logic [IDX_W-1:0]        span_q;
  logic signed [OFS_W-1:0] ofs_q;
  logic [FIELD_W-1:0]      ins_q;
  logic [IDX_W-1:0]        idx;
  logic                    pend_v;
  logic [IDX_W-1:0]        pend_idx;

  logic [ADDR_W-1:0]       loc_addr;
  logic [2:0]              loc_bitpos;
  logic [WID_W-1:0]        loc_width;
  logic [IDX_W-1:0]        loc_span;

  logic [WIN_W-1:0]        win;
  logic [WIN_W-1:0]        new_win;
  logic [7:0]              wr_byte;
  logic [FIELD_W-1:0]      op_value;
  logic [FIELD_W-1:0]      op_flag;
  logic                    op_n;
  logic                    op_z;

  bfu_locate #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_locate (
    .base       (base),
    .ofs        (ofs),
    .wcode      (wcode),
    .first_addr (loc_addr),
    .bitpos     (loc_bitpos),
    .width      (loc_width),
    .span       (loc_span)
  );

  bfu_window #(.NBYTES(WIN_BYTES)) u_window (
    .clk      (clk),
    .rst      (rst),
    .clr      (st == S_IDLE && start),
    .ld_en    (st == S_EXEC),
    .ld_win   (new_win),
    .cap_en   (pend_v),
    .cap_idx  (pend_idx),
    .cap_byte (mem_rdata),
    .sel_idx  (idx),
    .sel_byte (wr_byte),
    .win      (win)
  );

  bfu_fieldop #(.OFS_W(OFS_W)) u_fieldop (
    .op        (op_q),
    .win       (win),
    .bitpos    (bitpos_q),
    .width     (width_q),
    .ofs       (ofs_q),
    .ins_val   (ins_q),
    .new_win   (new_win),
    .value     (op_value),
    .flag_word (op_flag),
    .flag_n    (op_n),
    .flag_z    (op_z)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      op_q      <= OP_SEXT;
      addr_q    <= '0;
      bitpos_q  <= '0;
      width_q   <= WID_W'(FIELD_W);
      span_q    <= '0;
      ofs_q     <= '0;
      ins_q     <= '0;
      idx       <= '0;
      pend_v    <= 1'b0;
      pend_idx  <= '0;
      done      <= 1'b0;
      res_value <= '0;
      res_field <= '0;
      res_n     <= 1'b0;
      res_z     <= 1'b0;
    end else begin
      done     <= 1'b0;
      pend_v   <= (st == S_READ);
      pend_idx <= idx;
      unique case (st)
        S_IDLE: begin
          if (start) begin
            op_q     <= bf_op_e'(op);
            addr_q   <= loc_addr;
            bitpos_q <= loc_bitpos;
            width_q  <= loc_width;
            span_q   <= loc_span;
            ofs_q    <= ofs;
            ins_q    <= ins_val;
            idx      <= '0;
            st       <= S_READ;
          end
        end
        S_READ: begin
          if (idx == span_q) begin
            idx <= '0;
            st  <= S_DRAIN;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        S_DRAIN: st <= S_EXEC;
        S_EXEC: begin
          res_value <= op_value;
          res_field <= op_flag;
          res_n     <= op_n;
          res_z     <= op_z;
          if (op_writes(op_q)) begin
            st <= S_WRITE;
          end else begin
            done <= 1'b1;
            st   <= S_IDLE;
          end
        end
        S_WRITE: begin
          if (idx == span_q) begin
            idx  <= '0;
            done <= 1'b1;
            st   <= S_IDLE;
          end else begin
            idx <= idx + IDX_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign mem_req   = (st == S_READ) || (st == S_WRITE);
  assign mem_we    = (st == S_WRITE);
  assign mem_addr  = addr_q + ADDR_W'(idx);
  assign mem_wdata = wr_byte;

endmodule

// File: rtl/bfu_checker.sv
module bfu_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic [31:0]       res_field,
  input logic              res_n,
  input logic              res_z,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr
);

  p_done_pulse_r11: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req);

  p_start_busy_r11: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_addr_step_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && $past(mem_req) && (mem_we == $past(mem_we)))
      |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

  p_no_read_after_write_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we && $past(mem_req)) |-> !$past(mem_we));

  p_n_flag_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_n == res_field[31]));

  p_z_flag_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> (res_z == (res_field == 32'h0)));

endmodule

bind bitfield_mem_unit bfu_checker #(.ADDR_W(ADDR_W)) u_bfu_checker (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .busy      (busy),
  .done      (done),
  .res_field (res_field),
  .res_n     (res_n),
  .res_z     (res_z),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr)
);

// File: tb/bitfield_mem_unit_bench.sv
module bitfield_mem_unit_bench;

  localparam int ADDR_W = 16;
  localparam int OFS_W  = 32;
  localparam int MEMSZ  = 4096;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [2:0]        op = '0;
  logic [ADDR_W-1:0] base = '0;
  logic signed [OFS_W-1:0] ofs = '0;
  logic [4:0]        wcode = '0;
  logic [31:0]       ins_val = '0;
  logic              busy, done, res_n, res_z, mem_req, mem_we;
  logic [31:0]       res_value, res_field;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0]        mem_wdata;
  logic [7:0]        mem_rdata = '0;

  logic [7:0]        mem [0:MEMSZ-1];
  logic              poke_en = 1'b0;
  logic [11:0]       poke_a = '0;
  logic [7:0]        poke_d = '0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #10 clk = ~clk;

  bitfield_mem_unit #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_bitfield_mem_unit (
    .clk, .rst, .start, .op, .base, .ofs, .wcode, .ins_val,
    .busy, .done, .res_value, .res_field, .res_n, .res_z,
    .mem_req, .mem_we, .mem_addr, .mem_wdata, .mem_rdata
  );

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MEMSZ; i++) mem[i] <= 8'(i * 37 + 11);
    end else if (poke_en) begin
      mem[poke_a] <= poke_d;
    end else if (mem_req) begin
      if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[11:0]];
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 150000) begin
      n_fail = n_fail + 1;
      $display("FAIL R11 watchdog: actual %0d cycles expected completion", cycles);
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic poke(input int a, input logic [7:0] d);
    @(negedge clk);
    poke_en = 1'b1; poke_a = 12'(a); poke_d = d;
    @(negedge clk);
    poke_en = 1'b0;
  endtask

  function automatic string op_tag(input int o);
    case (o)
      0, 1, 7: return "R5";
      2:       return "R6";
      3, 4, 5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic run_op(input int o, input int b, input int f, input int wc,
                        input logic [31:0] iv, input bit ghost, input string tag);
    int w, bp, sadr, span, lat, first;
    bit wr;
    longint fv;
    logic [7:0] ob [5];
    logic [7:0] nb [5];
    logic [7:0] before_lo, before_hi;
    logic [31:0] lj_old, ins_lj, e_val, e_fld, a_port, e_port;

    w    = (wc == 0) ? 32 : wc;
    bp   = f & 7;
    sadr = (b + (f >>> 3)) & 16'hFFFF;
    span = (bp + w - 1) / 8;
    wr   = (o >= 2 && o <= 5);
    lat  = wr ? 2 * span + 5 : span + 4;
    for (int k = 0; k < 5; k++) begin
      ob[k] = (k <= span) ? mem[(sadr + k) & (MEMSZ - 1)] : 8'h00;
      nb[k] = ob[k];
    end
    before_lo = mem[(sadr - 1) & (MEMSZ - 1)];
    before_hi = mem[(sadr + span + 1) & (MEMSZ - 1)];
    fv = 0; first = -1;
    for (int i = 0; i < w; i++) begin
      int bb;
      logic bit_o, bit_n;
      bb    = bp + i;
      bit_o = ob[bb / 8][7 - (bb % 8)];
      fv    = (fv << 1) | longint'(bit_o);
      if (bit_o && first < 0) first = i;
      case (o)
        2: bit_n = iv[w - 1 - i];
        3: bit_n = ~bit_o;
        4: bit_n = 1'b0;
        5: bit_n = 1'b1;
        default: bit_n = bit_o;
      endcase
      nb[bb / 8][7 - (bb % 8)] = bit_n;
    end
    lj_old = 32'(fv << (32 - w));
    ins_lj = iv << (32 - w);
    case (o)
      0:       e_val = (fv[w - 1]) ? 32'(fv - (longint'(1) << w)) : 32'(fv);
      1, 7:    e_val = 32'(fv);
      2:       e_val = ins_lj;
      3, 4, 5: e_val = lj_old;
      default: e_val = 32'(f + ((first < 0) ? w : first));
    endcase
    e_fld = (o == 2) ? ins_lj : lj_old;

    @(negedge clk);
    chk("R11", "idle before start", {31'h0, busy}, 32'h0);
    start = 1'b1; op = 3'(o); base = 16'(b); ofs = f; wcode = 5'(wc); ins_val = iv;
    for (int c = 1; c <= lat; c++) begin
      @(negedge clk);
      start = 1'b0;
      if (ghost && c == 2) begin
        start = 1'b1; op = 3'd5; base = 16'h0500; ofs = 0; wcode = 5'd8;
      end
      a_port = {6'h0, mem_req, mem_we, (mem_req ? mem_addr : 16'h0),
                (mem_req && mem_we) ? mem_wdata : 8'h00};
      e_port = 32'h0;
      if (c <= span + 1)
        e_port = {6'h0, 1'b1, 1'b0, 16'(sadr + c - 1), 8'h00};
      else if (wr && c >= span + 4 && c <= 2 * span + 4)
        e_port = {6'h0, 1'b1, 1'b1, 16'(sadr + c - span - 4), nb[c - span - 4]};
      chk((c <= span + 1) ? "R2" : "R10", "memory port", a_port, e_port);
      chk("R11", "done timing", {31'h0, done}, {31'h0, (c == lat)});
      chk("R11", "busy timing", {31'h0, busy}, {31'h0, (c < lat)});
    end
    chk(op_tag(o), {"result ", tag}, res_value, e_val);
    chk("R9", {"flag word ", tag}, res_field, e_fld);
    chk("R9", "negative flag", {31'h0, res_n}, {31'h0, e_fld[31]});
    chk("R9", "zero flag", {31'h0, res_z}, {31'h0, (e_fld == 0)});
    for (int k = 0; k <= span; k++)
      chk(wr ? op_tag(o) : "R10", {"memory byte ", tag},
          {24'h0, mem[(sadr + k) & (MEMSZ - 1)]}, {24'h0, nb[k]});
    chk("R7", "byte below field", {24'h0, mem[(sadr - 1) & (MEMSZ - 1)]}, {24'h0, before_lo});
    chk("R7", "byte above field", {24'h0, mem[(sadr + span + 1) & (MEMSZ - 1)]}, {24'h0, before_hi});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R11", "reset busy", {31'h0, busy}, 32'h0);
    chk("R11", "reset done", {31'h0, done}, 32'h0);
    chk("R11", "reset mem_req", {31'h0, mem_req}, 32'h0);
    chk("R11", "reset result", res_value, 32'h0);

    run_op(1, 16'h100, 3, 5, 32'h0, 1'b0, "R4 single byte");
    run_op(0, 16'h100, 12, 12, 32'h0, 1'b0, "R4 two bytes");
    run_op(0, 16'h200, -3, 8, 32'h0, 1'b0, "R2 negative offset");
    run_op(1, 16'h120, 7, 0, 32'h0, 1'b0, "R1 R3 five bytes");
    run_op(2, 16'h300, 5, 9, 32'h0000_01A5, 1'b0, "insert nine");
    run_op(2, 16'h340, -13, 0, 32'hDEAD_BEEF, 1'b0, "R1 insert full");
    run_op(3, 16'h380, 2, 20, 32'h0, 1'b1, "R11 flip with ignored start");
    run_op(4, 16'h3C0, -1, 3, 32'h0, 1'b0, "R2 clear across back step");
    run_op(5, 16'h3E0, 30, 17, 32'h0, 1'b0, "R3 fill three bytes");
    poke(16'h400, 8'h00);
    poke(16'h401, 8'h20);
    run_op(6, 16'h400, 4, 10, 32'h0, 1'b0, "find set bit");
    poke(16'h43F, 8'h00);
    run_op(6, 16'h440, -6, 5, 32'h0, 1'b0, "find zero field");
    run_op(6, 16'h460, 0, 0, 32'h0, 1'b0, "R1 find full width");
    run_op(7, 16'h480, 9, 11, 32'h0, 1'b0, "alias code");
    run_op(0, 16'h4A0, 1, 31, 32'h0, 1'b0, "R3 wide signed");

    $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule